// File: doc/BRIEF.md
# Sequencer Interrupt Entry and Return Control

This block is the control core of a small microcoded sequencer, built around its interrupt handling. It holds the program counter, an eight-entry return-address stack, sixteen single-bit flags and a fetch / execute / loop state machine. Instructions come from an external program store addressed by the program counter. Conditional jump, call and return instructions each carry a five-bit condition: a negate bit and a four-bit flag index. The top flag (index 15) is the interrupt mask. Multi-register push and pop instructions take several cycles. They move a data-stack pointer, and the final pointer adjustment is left for the following fetch cycle.

The interrupt line is level sensitive. A request is latched and then considered only in a fetch cycle. When it is taken, the address that was about to be fetched goes onto the return stack, the mask flag is set and execution continues at a fixed vector. The interrupt return is not a separate opcode. It is the conditional return whose condition reads "mask flag set", which is the unused twin of the "always" code. When it fires it pops the return address, clears the mask and arms a one-shot defer bit. That bit guarantees that one instruction of the interrupted program runs before the next entry, so the program still advances with the line held high.

Top module: `seq_irq_core`

## Requirements
- R1: During reset the program counter, flags, stack depth and data-stack pointer read 0, the core is in the fetch state and no interrupt is acknowledged.
- R2: An instruction word is op[15:12], negate[11], flag index[10:7], address or count[6:0]. Opcodes: 0 no-op, 1 jump, 2 call, 3 return, 4 set flag, 5 clear flag, 6 push, 7 pop. A condition passes when flag[index] XOR negate is 1, except that negate 1 with index 15 always passes.
- R3: A passing call pushes the address after the call and jumps to the target. A passing return pops the top entry into the program counter. A failing condition only advances the program counter.
- R4: In a fetch cycle with a latched request, mask clear, no defer and no pending pointer adjustment, irq_ack is high. In the next cycle the program counter equals the vector (0x70), flag 15 is set and the interrupted fetch address is on top of the return stack.
- R5: A return with negate 0 and index 15 does nothing while flag 15 is clear. While flag 15 is set it pops, clears flag 15 and blocks the interrupt check of the following fetch.
- R6: With the request held high and a one-instruction handler, exactly one instruction of the interrupted program is fetched between two consecutive acknowledges.
- R7: A request pulse seen while masked stays latched and is taken at the first fetch after the mask is cleared.
- R8: Push n and pop n (n in [3:0]) run for n cycles without an interrupt. The data-stack pointer changes by +n or -n in the next fetch cycle, and no interrupt is taken in that fetch.
- R9: Set-flag and clear-flag write the indexed flag. Index 15 masks and unmasks interrupts.
- R10: The return stack holds 8 entries, and its depth output counts up to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Level-sensitive interrupt request |
| instr | input | 16 | Instruction word at address pc |
| pc | output | 7 | Program counter |
| in_fetch | output | 1 | Core is in a fetch cycle |
| irq_ack | output | 1 | Interrupt taken this cycle |
| flags | output | 16 | Flag register, bit 15 is the mask |
| rs_depth | output | 4 | Return-stack entries in use |
| rs_top | output | 7 | Top return-stack entry |
| dsp | output | 8 | Data-stack pointer |

## Verification
A lost or stuck defer bit shows up within two fetches of an interrupt return. Either irq_ack comes back with no program fetch in between, or it does not come back at all while the line is high. A wrong pending latch moves the acknowledge away from the exact fetch address expected after the mask is cleared. A leaked pointer adjustment shows as an acknowledge one fetch early with the data-stack pointer not yet updated. Return-stack damage shows in the depth and top outputs on the vector cycle, and again after the return.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_NOP  = 4'd0;
    localparam logic [OP_W-1:0] OP_JMP  = 4'd1;
    localparam logic [OP_W-1:0] OP_CALL = 4'd2;
    localparam logic [OP_W-1:0] OP_RET  = 4'd3;
    localparam logic [OP_W-1:0] OP_SETF = 4'd4;
    localparam logic [OP_W-1:0] OP_CLRF = 4'd5;
    localparam logic [OP_W-1:0] OP_PUSH = 4'd6;
    localparam logic [OP_W-1:0] OP_POP  = 4'd7;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_LOOP  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval #(
    parameter int FSEL_W = 4,
    localparam int NFLAG = 1 << FSEL_W
) (
    input  logic              negate,
    input  logic [FSEL_W-1:0] sel,
    input  logic [NFLAG-1:0]  flags,
    output logic              pass
);
    localparam logic [FSEL_W-1:0] SEL_TOP = '1;

    always_comb begin
        if (negate && (sel == SEL_TOP)) begin
            pass = 1'b1;
        end else begin
            pass = flags[sel] ^ negate;
        end
    end
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 7,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  top,
    output logic [CW-1:0] depth
);
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [CW-1:0] cnt;
    } rs_t;

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    rs_t rs_q, rs_d;
    logic [W-1:0] mem_q [DEPTH];
    logic [PW-1:0] top_idx;

    always_comb begin
        rs_d = rs_q;
        if (push) begin
            rs_d.ptr = rs_q.ptr + PW'(1);
            if (rs_q.cnt != FULL) rs_d.cnt = rs_q.cnt + CW'(1);
        end else if (pop && (rs_q.cnt != '0)) begin
            rs_d.ptr = rs_q.ptr - PW'(1);
            rs_d.cnt = rs_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)                             mem_q[i] <= '0;
            else if (push && (rs_q.ptr == PW'(i)))  mem_q[i] <= wdata;
        end
    end

    assign top_idx = rs_q.ptr - PW'(1);
    assign top     = mem_q[top_idx];
    assign depth   = rs_q.cnt;

    assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rs_q.cnt <= FULL);
    assert_push_grows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && (rs_q.cnt != FULL)) |=> (rs_q.cnt == $past(rs_q.cnt) + CW'(1)));
    assert_push_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (top == $past(wdata)));
endmodule

// File: rtl/seq_irq_gate.sv
module seq_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic irq,
    input  logic in_fetch,
    input  logic irq_masked,
    input  logic fixup_pend,
    input  logic reti_fire,
    output logic take
);
    typedef struct packed {
        logic pend;
        logic defer;
    } gate_t;

    gate_t gt_q, gt_d;

    always_comb begin
        take = in_fetch & gt_q.pend & ~irq_masked & ~gt_q.defer & ~fixup_pend;
        gt_d.pend  = irq | (gt_q.pend & ~take);
        gt_d.defer = gt_q.defer;
        if (in_fetch)  gt_d.defer = 1'b0;
        if (reti_fire) gt_d.defer = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gt_q <= '0;
        else        gt_q <= gt_d;
    end

    assert_irq_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> gt_q.pend);
    assert_reti_skips_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reti_fire |=> (in_fetch && !take));
endmodule

// File: rtl/seq_irq_core.sv
module seq_irq_core
    import seq_pkg::*;
#(
    parameter int AW       = 7,
    parameter int FSEL_W   = 4,
    parameter int RS_DEPTH = 8,
    parameter int DSP_W    = 8,
    parameter int CNT_W    = 4,
    parameter int VECTOR   = 'h70,
    localparam int NFLAG   = 1 << FSEL_W,
    localparam int IW      = OP_W + 1 + FSEL_W + AW,
    localparam int RCW     = $clog2(RS_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq,
    input  logic [IW-1:0]    instr,
    output logic [AW-1:0]    pc,
    output logic             in_fetch,
    output logic             irq_ack,
    output logic [NFLAG-1:0] flags,
    output logic [RCW-1:0]   rs_depth,
    output logic [AW-1:0]    rs_top,
    output logic [DSP_W-1:0] dsp
);
    localparam logic [AW-1:0]     VEC_A  = AW'(VECTOR);
    localparam int                MASK   = NFLAG - 1;
    localparam logic [FSEL_W-1:0] SEL_TOP = '1;
    localparam int                NEG_B  = AW + FSEL_W;

    typedef struct packed {
        seq_state_e       state;
        logic [AW-1:0]    pc;
        logic [IW-1:0]    ir;
        logic [NFLAG-1:0] flags;
        logic [CNT_W-1:0] cnt;
        logic [DSP_W-1:0] fix_amt;
        logic             fixup;
        logic [DSP_W-1:0] dsp;
    } core_t;

    core_t st_q, st_d;

    logic [OP_W-1:0]   ir_op;
    logic              ir_neg;
    logic [FSEL_W-1:0] ir_sel;
    logic [AW-1:0]     ir_addr;
    logic [CNT_W-1:0]  ir_cnt;
    logic              cond_pass;
    logic              take;
    logic              rs_push, rs_pop, reti_fire;
    logic [AW-1:0]     rs_wdata;
    logic [DSP_W-1:0]  cnt_ext;

    assign ir_op   = st_q.ir[IW-1 -: OP_W];
    assign ir_neg  = st_q.ir[NEG_B];
    assign ir_sel  = st_q.ir[AW +: FSEL_W];
    assign ir_addr = st_q.ir[AW-1:0];
    assign ir_cnt  = st_q.ir[CNT_W-1:0];

    seq_cond_eval #(.FSEL_W(FSEL_W)) u_cond (
        .negate (ir_neg),
        .sel    (ir_sel),
        .flags  (st_q.flags),
        .pass   (cond_pass)
    );

    seq_irq_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq        (irq),
        .in_fetch   (in_fetch),
        .irq_masked (st_q.flags[MASK]),
        .fixup_pend (st_q.fixup),
        .reti_fire  (reti_fire),
        .take       (take)
    );

    seq_ret_stack #(.DEPTH(RS_DEPTH), .W(AW)) u_rs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rs_push),
        .pop   (rs_pop),
        .wdata (rs_wdata),
        .top   (rs_top),
        .depth (rs_depth)
    );

    assign in_fetch = (st_q.state == ST_FETCH);
    assign irq_ack  = take;

    always_comb begin
        st_d      = st_q;
        rs_push   = 1'b0;
        rs_pop    = 1'b0;
        rs_wdata  = st_q.pc;
        reti_fire = 1'b0;
        cnt_ext   = {{(DSP_W-CNT_W){1'b0}}, ir_cnt};
        unique case (st_q.state)
            ST_FETCH: begin
                if (take) begin
                    rs_push           = 1'b1;
                    st_d.pc           = VEC_A;
                    st_d.flags[MASK]  = 1'b1;
                end else begin
                    st_d.ir    = instr;
                    st_d.pc    = st_q.pc + AW'(1);
                    st_d.state = ST_EXEC;
                    if (st_q.fixup) begin
                        st_d.dsp   = st_q.dsp + st_q.fix_amt;
                        st_d.fixup = 1'b0;
                    end
                end
            end
            ST_EXEC: begin
                st_d.state = ST_FETCH;
                case (ir_op)
                    OP_JMP: begin
                        if (cond_pass) st_d.pc = ir_addr;
                    end
                    OP_CALL: begin
                        if (cond_pass) begin
                            rs_push = 1'b1;
                            st_d.pc = ir_addr;
                        end
                    end
                    OP_RET: begin
                        if (cond_pass) begin
                            rs_pop  = 1'b1;
                            st_d.pc = rs_top;
                            if (!ir_neg && (ir_sel == SEL_TOP)) begin
                                st_d.flags[MASK] = 1'b0;
                                reti_fire        = 1'b1;
                            end
                        end
                    end
                    OP_SETF: st_d.flags[ir_sel] = 1'b1;
                    OP_CLRF: st_d.flags[ir_sel] = 1'b0;
                    OP_PUSH, OP_POP: begin
                        if (ir_cnt != '0) begin
                            st_d.fix_amt = (ir_op == OP_PUSH) ? cnt_ext
                                                              : (~cnt_ext + DSP_W'(1));
                            if (ir_cnt == CNT_W'(1)) begin
                                st_d.fixup = 1'b1;
                            end else begin
                                st_d.cnt   = ir_cnt - CNT_W'(2);
                                st_d.state = ST_LOOP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            ST_LOOP: begin
                if (st_q.cnt == '0) begin
                    st_d.state = ST_FETCH;
                    st_d.fixup = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            default: st_d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc    = st_q.pc;
    assign flags = st_q.flags;
    assign dsp   = st_q.dsp;

    assert_entry_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (st_q.flags[MASK] && (st_q.pc == VEC_A) && (st_q.state == ST_FETCH)));
    assert_entry_saves_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (rs_top == $past(st_q.pc)));
    assert_no_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);
    assert_loop_atomic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_LOOP) |=> !irq_ack);
    assert_reti_unmasks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reti_fire |=> (!st_q.flags[MASK] && !irq_ack));
endmodule

// File: tb/tb_seq_irq_core.sv
`timescale 1ns/1ps
module tb_seq_irq_core;
    localparam int VEC = 'h70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [15:0] instr;
    logic [6:0]  pc;
    logic        in_fetch, irq_ack;
    logic [15:0] flags;
    logic [3:0]  rs_depth;
    logic [6:0]  rs_top;
    logic [7:0]  dsp;

    logic [15:0] prog [0:127];
    assign instr = prog[pc];

    always #2.5 clk = ~clk;

    seq_irq_core dut (
        .clk(clk), .rst_n(rst_n), .irq(irq), .instr(instr), .pc(pc),
        .in_fetch(in_fetch), .irq_ack(irq_ack), .flags(flags),
        .rs_depth(rs_depth), .rs_top(rs_top), .dsp(dsp)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int neg, input int sel, input int a);
        return {op[3:0], neg[0], sel[3:0], a[6:0]};
    endfunction
    function automatic logic [15:0] jmp_always(input int a);  return enc(1, 1, 15, a); endfunction
    function automatic logic [15:0] call_always(input int a); return enc(2, 1, 15, a); endfunction
    function automatic logic [15:0] ret_always();             return enc(3, 1, 15, 0); endfunction
    function automatic logic [15:0] reti_op();                return enc(3, 0, 15, 0); endfunction

    // monitor state
    bit [127:0] visited;
    int acks, main_since, first_ack_pc, first_ack_dsp;
    bit pend_chk, exact_one;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_chk) begin
                chk(pc == 7'(VEC) && flags[15], "R4_vector", int'(pc), VEC);
                pend_chk = 0;
            end
            if (irq_ack) begin
                chk(!flags[15], "R4_unmasked", int'(flags[15]), 0);
                chk(rs_depth == 0, "R10_depth_at_ack", int'(rs_depth), 0);
                if (acks > 0) begin
                    if (exact_one) chk(main_since == 1, "R6_one_between", main_since, 1);
                    else           chk(main_since >= 1, "R6_progress", main_since, 1);
                end
                if (acks == 0) begin
                    first_ack_pc  = int'(pc);
                    first_ack_dsp = int'(dsp);
                end
                acks++;
                main_since = 0;
                pend_chk = 1;
            end else if (in_fetch && pc < 7'(VEC)) begin
                visited[pc] = 1'b1;
                main_since++;
            end
        end
    end

    task automatic clear_prog();
        for (int i = 0; i < 128; i++) prog[i] = 16'h0000;
        prog[VEC] = reti_op();
    endtask

    task automatic do_reset(input bit irq_lvl);
        rst_n = 1'b0;
        irq = irq_lvl;
        repeat (3) @(negedge clk);
        visited = '0; acks = 0; main_since = 0; pend_chk = 0;
        first_ack_pc = -1; first_ack_dsp = -1;
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_fetch(input int a, input int lim, output bit hit);
        hit = 0;
        for (int i = 0; i < lim && !hit; i++) begin
            @(negedge clk);
            if (in_fetch && !irq_ack && pc == 7'(a)) hit = 1;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit hit;
        void'($urandom(32'd4242));
        exact_one = 0;
        clear_prog();

        // R1 reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(pc == 0 && flags == 0, "R1_pc_flags", int'(pc), 0);
        chk(rs_depth == 0 && dsp == 0, "R1_stack", int'(rs_depth) + int'(dsp), 0);
        chk(in_fetch && !irq_ack, "R1_fetch", int'(in_fetch), 1);

        // R2 / R9 conditions, directed index-15 cases then random
        for (int it = 0; it < 28; it++) begin
            int sel, neg, val, exp_take;
            if (it < 4) begin sel = 15; neg = (it >> 1) & 1; val = it & 1; end
            else begin
                sel = $urandom_range(0, 15); neg = $urandom_range(0, 1); val = $urandom_range(0, 1);
            end
            exp_take = (neg == 1 && sel == 15) ? 1 : (val ^ neg);
            clear_prog();
            prog[0] = enc(val ? 4 : 5, 0, sel, 0);
            prog[1] = enc(1, neg, sel, 20);
            prog[2] = jmp_always(2);
            prog[20] = jmp_always(20);
            do_reset(0);
            run(12);
            chk(flags[sel] == val[0], "R9_flag_write", int'(flags[sel]), val);
            chk(visited[20] == exp_take[0], "R2_cond", int'(visited[20]), exp_take);
        end

        // R3 call / return, conditional return not taken
        clear_prog();
        prog[0] = call_always(16); prog[1] = jmp_always(1);
        prog[16] = call_always(32); prog[17] = ret_always();
        prog[32] = enc(3, 0, 5, 0); prog[33] = ret_always();
        do_reset(0);
        wait_fetch(32, 40, hit);
        chk(hit && rs_depth == 2, "R3_depth2", int'(rs_depth), 2);
        chk(rs_top == 17, "R3_top", int'(rs_top), 17);
        run(20);
        chk(rs_depth == 0 && visited[1] && visited[17], "R3_unwind", int'(rs_depth), 0);
        chk(visited[33] == 1'b1, "R2_ret_not_taken", int'(visited[33]), 1);

        // R10 eight-deep chain
        clear_prog();
        for (int k = 0; k < 8; k++) prog[k] = call_always(k + 1);
        prog[8] = jmp_always(8);
        do_reset(0);
        run(40);
        chk(rs_depth == 8, "R10_full_depth", int'(rs_depth), 8);
        chk(rs_top == 8, "R10_top", int'(rs_top), 8);

        // R4 entry timing
        clear_prog();
        prog[10] = jmp_always(10);
        do_reset(0);
        wait_fetch(2, 20, hit);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        @(negedge clk);
        chk(irq_ack == 1'b1 && pc == 3, "R4_ack_pc", int'(pc), 3);
        @(negedge clk);
        chk(pc == 7'(VEC) && flags[15], "R4_at_vector", int'(pc), VEC);
        chk(rs_depth == 1 && rs_top == 3, "R4_saved_pc", int'(rs_top), 3);
        run(10);
        chk(!flags[15] && rs_depth == 0, "R5_return_unmask", int'(flags[15]), 0);
        chk(visited[3] && visited[4] && acks == 1, "R5_resume", acks, 1);

        // R5 interrupt-return while unmasked is ignored
        clear_prog();
        prog[0] = call_always(4); prog[1] = jmp_always(1);
        prog[4] = reti_op(); prog[5] = jmp_always(5);
        do_reset(0);
        run(20);
        chk(visited[5] && !visited[1], "R5_ignored", int'(visited[1]), 0);
        chk(rs_depth == 1 && !flags[15], "R5_no_pop", int'(rs_depth), 1);

        // R6 forward progress with irq held high
        clear_prog();
        prog[63] = jmp_always(0);
        exact_one = 1;
        do_reset(1);
        run(400);
        exact_one = 0;
        chk(acks >= 60, "R6_entries", acks, 60);
        chk(visited[40] == 1'b1, "R6_main_advances", int'(visited[40]), 1);
        irq = 1'b0;

        // R7 pulse while masked is kept
        clear_prog();
        prog[0] = enc(4, 0, 15, 0);
        prog[10] = enc(5, 0, 15, 0);
        prog[20] = jmp_always(20);
        do_reset(0);
        wait_fetch(3, 20, hit);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        run(40);
        chk(acks == 1, "R7_taken_once", acks, 1);
        chk(first_ack_pc == 11, "R7_after_unmask", first_ack_pc, 11);

        // R8 multi-cycle push / pop with irq held high
        clear_prog();
        prog[0] = enc(6, 0, 0, 5);
        prog[2] = enc(7, 0, 0, 3);
        prog[3] = jmp_always(3);
        do_reset(1);
        run(60);
        chk(first_ack_pc == 2, "R8_no_take_on_fixup", first_ack_pc, 2);
        chk(first_ack_dsp == 5, "R8_push_amount", first_ack_dsp, 5);
        chk(dsp == 2, "R8_pop_amount", int'(dsp), 2);
        irq = 1'b0;

        // random mix: invariants checked by the monitor on every acknowledge
        clear_prog();
        for (int a = 0; a < 64; a++) begin
            int k;
            k = $urandom_range(0, 6);
            case (k)
                0: prog[a] = 16'h0000;
                1: prog[a] = enc(4, 0, $urandom_range(0, 14), 0);
                2: prog[a] = enc(5, 0, $urandom_range(0, 14), 0);
                3: prog[a] = enc(4, 0, 15, 0);
                4: prog[a] = enc(5, 0, 15, 0);
                5: prog[a] = enc(6, 0, 0, $urandom_range(0, 3));
                default: prog[a] = enc(7, 0, 0, $urandom_range(0, 3));
            endcase
        end
        prog[64] = jmp_always(0);
        do_reset(0);
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 5) == 0) irq = ~irq;
        end
        chk(acks > 0, "R4_random_entries", acks, 1);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule